// File: doc/BRIEF.md
# Receive Fill Watermark and Request-to-Send Control

This block watches the occupancy count of a receive FIFO and produces three registered outputs. The first is a trigger flag. It rises when the occupancy reaches a programmable trigger level, and the interrupt logic beside it consumes the flag. The second is a flow-delay flag. It rises when the occupancy reaches a second programmable level and is meant only to be read as status. The third is the active-low request-to-send pin.

In hardware flow control mode the request-to-send pin is withdrawn once the flow-delay level is reached. It is granted again only after the FIFO has drained to at least four entries below that level, which gives four entries of hysteresis. In software mode the pin simply follows a control bit. Both threshold registers are five bits wide. A trigger level of zero turns the trigger off, and a flow-delay level below four turns flow delay off. The hysteresis state keeps updating in both modes, so a switch into hardware mode takes effect at once with the correct state.

Top module: `rx_fill_flow`

## Requirements
- R1: While reset is active and in the first cycle after it, `trig_hit` = 0, `flow_hit` = 0 and `rts_n` = 0, where a low `rts_n` means request-to-send is asserted.
- R2: With `trig_level` nonzero, `trig_hit` is 1 one clock after a cycle in which `fill_level` >= `trig_level`, and 0 one clock after a cycle in which it is lower.
- R3: With `trig_level` = 0, `trig_hit` is 0 for any `fill_level`.
- R4: With `flow_level` >= 4, `flow_hit` is 1 one clock after a cycle in which `fill_level` >= `flow_level`, and 0 otherwise.
- R5: With `flow_level` < 4, `flow_hit` is 0 and, in hardware mode, `rts_n` is 0 for any `fill_level`.
- R6: In hardware mode (`hw_flow_en` = 1) with flow delay enabled, `rts_n` is 1 one clock after a cycle in which `fill_level` >= `flow_level`.
- R7: In hardware mode, once deasserted, `rts_n` stays 1 while `fill_level` lies between `flow_level`-3 and `flow_level`-1. It returns to 0 one clock after a cycle in which `fill_level` <= `flow_level`-4.
- R8: In software mode (`hw_flow_en` = 0), `rts_n` equals the inverse of `sw_rts_req` from the previous cycle, whatever the fill and thresholds.
- R9: The hysteresis state keeps updating in software mode, so on a switch to hardware mode `rts_n` reflects the fill history seen during software mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_level | input | LVL_W | Current receive FIFO occupancy |
| trig_level | input | THR_W | Trigger threshold, 0 turns it off |
| flow_level | input | THR_W | Flow-delay threshold, below 4 turns it off |
| hw_flow_en | input | 1 | 1 selects hardware flow control |
| sw_rts_req | input | 1 | Software request-to-send, 1 means asserted |
| trig_hit | output | 1 | Occupancy has reached the trigger level |
| flow_hit | output | 1 | Occupancy has reached the flow-delay level |
| rts_n | output | 1 | Request-to-send pin, active low |

## Verification
A stale or wrong hysteresis bit shows up on `rts_n` in the clock right after the fill crosses the upper or lower edge of the band. A ramp that rises through the flow-delay level and then falls back exposes it, and the bench runs that ramp for every threshold value. Off-by-one compare errors flip `trig_hit` or `flow_hit` exactly at the threshold occupancy. The bench sweeps every occupancy against every threshold, so such an error surfaces at that single point. A mode-switch test shows whether the hysteresis state was held frozen during software mode, because `rts_n` is then wrong in the first clock after the switch.

// File: rtl/rx_fill_flow.sv
module rx_fill_flow #(
  parameter int LVL_W = 6,
  parameter int THR_W = 5,
  parameter int HYST  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] fill_level,
  input  logic [THR_W-1:0] trig_level,
  input  logic [THR_W-1:0] flow_level,
  input  logic             hw_flow_en,
  input  logic             sw_rts_req,
  output logic             trig_hit,
  output logic             flow_hit,
  output logic             rts_n
);
  localparam int CW = ((LVL_W > THR_W) ? LVL_W : THR_W) + 2;

  logic [CW-1:0] fill_x, trig_x, flow_x;
  logic          trig_on, flow_on, at_trig, at_flow, drained;
  logic          req_q, req_d;

  assign fill_x  = CW'(fill_level);
  assign trig_x  = CW'(trig_level);
  assign flow_x  = CW'(flow_level);
  assign trig_on = trig_level != '0;
  assign flow_on = flow_x >= CW'(HYST);
  assign at_trig = trig_on && (fill_x >= trig_x);
  assign at_flow = flow_on && (fill_x >= flow_x);
  assign drained = (fill_x + CW'(HYST)) <= flow_x;

  always_comb begin
    req_d = req_q;
    if (!flow_on)     req_d = 1'b1;
    else if (at_flow) req_d = 1'b0;
    else if (drained) req_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= 1'b1;
      trig_hit <= 1'b0;
      flow_hit <= 1'b0;
      rts_n    <= 1'b0;
    end else begin
      req_q    <= req_d;
      trig_hit <= at_trig;
      flow_hit <= at_flow;
      rts_n    <= hw_flow_en ? ~req_d : ~sw_rts_req;
    end
  end

  // R3
  trig_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_hit |-> $past(trig_level) != '0);

  // R5
  flow_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flow_hit |-> $past(flow_level) >= THR_W'(HYST));

  // R6
  hw_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hw_flow_en) && flow_hit) |-> rts_n);

  // R8
  sw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(hw_flow_en) |-> (rts_n == !$past(sw_rts_req)));

  // R7
  regrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && !$past(req_q)) |->
      (($past(flow_level) < THR_W'(HYST)) ||
       (CW'($past(fill_level)) + CW'(HYST) <= CW'($past(flow_level)))));
endmodule

// File: tb/rx_fill_flow_tb.sv
module rx_fill_flow_tb;
  localparam int CLK_P = 10;
  localparam int LVL_W = 6;
  localparam int THR_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LVL_W-1:0] fill_level = '0;
  logic [THR_W-1:0] trig_level = '0;
  logic [THR_W-1:0] flow_level = '0;
  logic hw_flow_en = 1'b1;
  logic sw_rts_req = 1'b1;
  logic trig_hit, flow_hit, rts_n;

  int n_run = 0;
  int n_fail = 0;
  int m_req = 1;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rx_fill_flow #(.LVL_W(LVL_W), .THR_W(THR_W), .HYST(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .fill_level(fill_level),
    .trig_level(trig_level), .flow_level(flow_level),
    .hw_flow_en(hw_flow_en), .sw_rts_req(sw_rts_req),
    .trig_hit(trig_hit), .flow_hit(flow_hit), .rts_n(rts_n));

  task automatic check(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d (fill=%0d trig=%0d flow=%0d hw=%0d)",
               req, act, exp, fill_level, trig_level, flow_level, hw_flow_en);
    end
  endtask

  task automatic step(int f);
    int fl;
    fill_level = LVL_W'(f);
    fl = int'(flow_level);
    if (fl < 4) m_req = 1;
    else if (f >= fl) m_req = 0;
    else if (f + 4 <= fl) m_req = 1;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    int f, t, fl, exp_rts;
    f = int'(fill_level); t = int'(trig_level); fl = int'(flow_level);
    check({tag, " trig"}, int'(trig_hit), (t != 0 && f >= t) ? 1 : 0);
    check({tag, " flow"}, int'(flow_hit), (fl >= 4 && f >= fl) ? 1 : 0);
    exp_rts = hw_flow_en ? (1 - m_req) : (sw_rts_req ? 0 : 1);
    check({tag, " rts"}, int'(rts_n), exp_rts);
  endtask

  initial begin
    #(CLK_P * 50000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1 during reset
    check("R1 trig", int'(trig_hit), 0);
    check("R1 flow", int'(flow_hit), 0);
    check("R1 rts", int'(rts_n), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 post trig", int'(trig_hit), 0);
    check("R1 post rts", int'(rts_n), 0);

    // R2 R3 R5: every trigger level against every fill, flow delay off
    hw_flow_en = 1'b1;
    flow_level = 5'd2;
    for (int t = 0; t < 32; t++) begin
      trig_level = THR_W'(t);
      for (int f = 0; f <= 32; f++) begin
        step(f);
        check(t == 0 ? "R3" : "R2", int'(trig_hit), (t != 0 && f >= t) ? 1 : 0);
        check("R5 flow", int'(flow_hit), 0);
        check("R5 rts", int'(rts_n), 0);
      end
    end

    // R4 R6 R7: rising then falling ramps for every flow-delay level
    trig_level = '0;
    for (int fl = 0; fl < 32; fl++) begin
      flow_level = THR_W'(fl);
      for (int f = 0; f <= 32; f++) begin
        step(f);
        check_all("R4/R6 up");
      end
      for (int f = 32; f >= 0; f--) begin
        step(f);
        check_all("R7 down");
      end
      // R7 bounce inside band: stays deasserted
      if (fl >= 4) begin
        step(fl);
        step(fl - 3);
        check("R7 band", int'(rts_n), 1);
        step(fl - 1);
        check("R7 band", int'(rts_n), 1);
        step(fl - 4);
        check("R7 edge", int'(rts_n), 0);
      end
    end

    // R8 software mode: pin follows control bit regardless of fill
    hw_flow_en = 1'b0;
    flow_level = 5'd8;
    trig_level = 5'd3;
    for (int f = 0; f <= 12; f++) begin
      sw_rts_req = f[0];
      step(f);
      check("R8 sw", int'(rts_n), f[0] ? 0 : 1);
      check_all("R8 sw");
    end
    // R9 state tracked in software mode: fill reached 12 then 6 (in band)
    step(6);
    hw_flow_en = 1'b1;
    step(6);
    check("R9 switch", int'(rts_n), 1);
    step(4);
    check("R9 drained", int'(rts_n), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule